// File: doc/BRIEF.md
# DRAM Bank Command Timing Guard

This block guards one DRAM bank inside a command scheduler. It keeps its own cycle timestamp and reacts to single-cycle issue pulses for activate, read, write and precharge. From these it keeps three deadlines: the earliest cycle at which a column command may go out, the earliest cycle for a precharge, and the earliest cycle for the next activate. The scheduler reads a registered "allowed" flag and a saturated count of remaining cycles for each command class, and uses them to pick legal commands.

The read and write paths set the precharge deadline in different ways. A read counts its read-to-precharge delay from the cycle it is issued. A write counts its write-recovery delay from the end of its data burst, which comes CAS latency plus burst time after the issue. Every update takes the later of the old deadline and the new one, so a deadline never moves earlier. The read-to-precharge delay is worked out at elaboration time: it is either the larger of a minimum clock count and a time in picoseconds rounded up to whole cycles, or the burst time when the device uses single data rate. A command issued before its deadline sets a sticky violation flag.

Top module: `bank_timing_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it, all three allowed flags are 1, all three wait counts are 0, the violation flag is 0 and the timestamp is 0.
- R2: A read or write issued at timestamp T blocks column commands until T+TBURST. In cycle T+k the column flag is 0 and the column wait is TBURST-k, for 1 <= k < TBURST.
- R3: A read issued at T blocks precharge until at least T+TRTP.
- R4: A write issued at T blocks precharge until at least T+TCL+TBURST+TWR.
- R5: A new constraint never makes a deadline earlier: the deadline becomes the maximum of its old value and the new value.
- R6: An activate issued at T blocks precharge until at least T+TRAS and column commands until at least T+TRCD.
- R7: A precharge issued at T blocks the next activate until T+TRP.
- R8: A command issued while its allowed flag is 0 sets the violation flag in the next cycle. The flag then stays 1 until reset.
- R9: TRTP equals TBURST when SDR is set. Otherwise it is max(RTP_MIN_CK, ceil(RTP_PS/CLK_PS)). The defaults give 6.
- R10: The timestamp output rises by exactly one every cycle after reset.
- R11: The wait counts saturate at 2^WAIT_W-1, and an allowed flag is 1 exactly when its wait count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| act_i | input | 1 | Activate issued this cycle |
| rd_i | input | 1 | Read issued this cycle |
| wr_i | input | 1 | Write issued this cycle |
| pre_i | input | 1 | Precharge issued this cycle |
| cycle_o | output | 32 | Current timestamp |
| col_ok_o | output | 1 | Column command legal this cycle |
| pre_ok_o | output | 1 | Precharge legal this cycle |
| act_ok_o | output | 1 | Activate legal this cycle |
| col_wait_o | output | WAIT_W | Cycles left until a column command is legal |
| pre_wait_o | output | WAIT_W | Cycles left until a precharge is legal |
| act_wait_o | output | WAIT_W | Cycles left until an activate is legal |
| viol_o | output | 1 | Sticky timing violation flag |

## Verification
A wrong deadline register shows up in the cycle right after the command that loaded it, because the wait count in that cycle already holds the full remaining distance. A deadline that was shortened by a later, weaker command shows up at once as a wait count that is too small. This is why the tests issue a read and a write after an activate and check the wait count the very next cycle. An off-by-one error in the comparison shows only at the edge cycle, so each delay is sampled both at its last blocked cycle and at its first legal cycle.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;
  localparam int unsigned STAMP_W = 32;
  typedef logic [STAMP_W-1:0] stamp_t;

  function automatic stamp_t sat_add(stamp_t a, int unsigned b);
    stamp_t lim;
    lim = '1;
    if (a > lim - stamp_t'(b)) return lim;
    return a + stamp_t'(b);
  endfunction

  function automatic stamp_t stamp_max(stamp_t a, stamp_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cycle_stamp.sv
module cycle_stamp
  import bank_timing_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output stamp_t now_o,
  output stamp_t now_next_o
);
  stamp_t cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign now_o      = cnt_q;
  assign now_next_o = rst ? '0 : cnt_q + 1'b1;
endmodule

// File: rtl/deadline_track.sv
module deadline_track
  import bank_timing_pkg::*;
#(
  parameter int unsigned NCAND  = 1,
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  stamp_t            now_i,
  input  stamp_t            now_next_i,
  input  logic [NCAND-1:0]  cand_vld_i,
  input  stamp_t            cand_at_i [NCAND],
  output logic              ok_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic              early_o
);
  localparam stamp_t WAIT_MAX = stamp_t'((64'd1 << WAIT_W) - 1);

  stamp_t            at_q, at_next, gap;
  logic              ok_q;
  logic [WAIT_W-1:0] wait_q;

  always_comb begin
    at_next = at_q;
    for (int i = 0; i < NCAND; i++) begin
      if (cand_vld_i[i]) at_next = stamp_max(at_next, cand_at_i[i]);
    end
    gap = (at_next > now_next_i) ? at_next - now_next_i : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      at_q   <= '0;
      ok_q   <= 1'b1;
      wait_q <= '0;
    end else begin
      at_q   <= at_next;
      ok_q   <= (gap == '0);
      wait_q <= (gap > WAIT_MAX) ? WAIT_MAX[WAIT_W-1:0] : gap[WAIT_W-1:0];
    end
  end

  assign ok_o    = ok_q;
  assign wait_o  = wait_q;
  assign early_o = (now_i < at_q);
endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import bank_timing_pkg::*;
#(
  parameter int unsigned TBURST     = 4,
  parameter int unsigned TCL        = 11,
  parameter int unsigned TWR        = 12,
  parameter int unsigned TRAS       = 28,
  parameter int unsigned TRCD       = 11,
  parameter int unsigned TRP        = 11,
  parameter int unsigned CLK_PS     = 1250,
  parameter int unsigned RTP_PS     = 7500,
  parameter int unsigned RTP_MIN_CK = 4,
  parameter bit          SDR        = 1'b0,
  parameter int unsigned WAIT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              pre_i,
  output logic [31:0]       cycle_o,
  output logic              col_ok_o,
  output logic              pre_ok_o,
  output logic              act_ok_o,
  output logic [WAIT_W-1:0] col_wait_o,
  output logic [WAIT_W-1:0] pre_wait_o,
  output logic [WAIT_W-1:0] act_wait_o,
  output logic              viol_o
);
  localparam int unsigned RTP_FROM_PS = (RTP_PS + CLK_PS - 1) / CLK_PS;
  localparam int unsigned RTP_DDR     = (RTP_FROM_PS > RTP_MIN_CK) ? RTP_FROM_PS : RTP_MIN_CK;
  localparam int unsigned TRTP        = SDR ? TBURST : RTP_DDR;
  localparam int unsigned WR_TO_PRE   = TCL + TBURST + TWR;

  stamp_t now, now_next;
  logic   col_early, pre_early, act_early;
  logic   viol_q;

  stamp_t col_cand [3];
  stamp_t pre_cand [3];
  stamp_t act_cand [1];

  cycle_stamp u_stamp (
    .clk(clk), .rst(rst), .now_o(now), .now_next_o(now_next)
  );

  // candidate order: activate, read, write
  always_comb begin
    col_cand[0] = sat_add(now, TRCD);
    col_cand[1] = sat_add(now, TBURST);
    col_cand[2] = sat_add(now, TBURST);
    pre_cand[0] = sat_add(now, TRAS);
    pre_cand[1] = sat_add(now, TRTP);
    pre_cand[2] = sat_add(now, WR_TO_PRE);
    act_cand[0] = sat_add(now, TRP);
  end

  deadline_track #(.NCAND(3), .WAIT_W(WAIT_W)) u_col (
    .clk(clk), .rst(rst), .now_i(now), .now_next_i(now_next),
    .cand_vld_i({wr_i, rd_i, act_i}), .cand_at_i(col_cand),
    .ok_o(col_ok_o), .wait_o(col_wait_o), .early_o(col_early)
  );

  deadline_track #(.NCAND(3), .WAIT_W(WAIT_W)) u_pre (
    .clk(clk), .rst(rst), .now_i(now), .now_next_i(now_next),
    .cand_vld_i({wr_i, rd_i, act_i}), .cand_at_i(pre_cand),
    .ok_o(pre_ok_o), .wait_o(pre_wait_o), .early_o(pre_early)
  );

  deadline_track #(.NCAND(1), .WAIT_W(WAIT_W)) u_act (
    .clk(clk), .rst(rst), .now_i(now), .now_next_i(now_next),
    .cand_vld_i(pre_i), .cand_at_i(act_cand),
    .ok_o(act_ok_o), .wait_o(act_wait_o), .early_o(act_early)
  );

  always_ff @(posedge clk) begin
    if (rst) viol_q <= 1'b0;
    else if ((act_i && act_early) || ((rd_i || wr_i) && col_early) ||
             (pre_i && pre_early))
      viol_q <= 1'b1;
  end

  assign viol_o  = viol_q;
  assign cycle_o = now;
endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk #(
  parameter int unsigned TBURST = 4,
  parameter int unsigned TRAS   = 28,
  parameter int unsigned WAIT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              act_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              pre_i,
  input logic [31:0]       cycle_o,
  input logic              col_ok_o,
  input logic              pre_ok_o,
  input logic              act_ok_o,
  input logic [WAIT_W-1:0] col_wait_o,
  input logic [WAIT_W-1:0] pre_wait_o,
  input logic [WAIT_W-1:0] act_wait_o,
  input logic              viol_o
);
  if (TBURST > 1 && TBURST - 1 < (1 << WAIT_W)) begin : g_col
    assert_col_block_R2: assert property (@(posedge clk) disable iff (rst)
      (rd_i || wr_i) |=> (!col_ok_o && col_wait_o >= WAIT_W'(TBURST - 1)));
  end

  if (TRAS > 1 && TRAS - 1 < (1 << WAIT_W)) begin : g_ras
    assert_act_pre_R6: assert property (@(posedge clk) disable iff (rst)
      act_i |=> (!pre_ok_o && pre_wait_o >= WAIT_W'(TRAS - 1)));
  end

  assert_no_shorten_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(pre_wait_o) != '0) |-> (pre_wait_o >= $past(pre_wait_o) - 1'b1));

  assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    viol_o |=> viol_o);

  assert_viol_set_R8: assert property (@(posedge clk) disable iff (rst)
    (pre_i && !pre_ok_o) |=> viol_o);

  assert_flag_wait_R11: assert property (@(posedge clk) disable iff (rst)
    (act_ok_o == (act_wait_o == '0)) && (col_ok_o == (col_wait_o == '0)));

  assert_stamp_step_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cycle_o == $past(cycle_o) + 32'd1));
endmodule

bind bank_timing_guard bank_timing_guard_chk #(
  .TBURST(TBURST), .TRAS(TRAS), .WAIT_W(WAIT_W)
) u_chk (.*);

// File: tb/tb_bank_timing_guard.sv
module tb_bank_timing_guard;
  localparam int TBURST = 4, TCL = 11, TWR = 12, TRAS = 28, TRCD = 11, TRP = 11;
  localparam int WAIT_W = 8;
  // R9: max(4, ceil(7500/1250)) = 6
  localparam int EXP_RTP = ((7500 + 1249) / 1250 > 4) ? (7500 + 1249) / 1250 : 4;

  logic clk = 1'b0, rst = 1'b1;
  logic act_i = 0, rd_i = 0, wr_i = 0, pre_i = 0;
  logic [31:0] cycle_o;
  logic col_ok_o, pre_ok_o, act_ok_o, viol_o;
  logic [WAIT_W-1:0] col_wait_o, pre_wait_o, act_wait_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bank_timing_guard dut (
    .clk(clk), .rst(rst), .act_i(act_i), .rd_i(rd_i), .wr_i(wr_i), .pre_i(pre_i),
    .cycle_o(cycle_o), .col_ok_o(col_ok_o), .pre_ok_o(pre_ok_o), .act_ok_o(act_ok_o),
    .col_wait_o(col_wait_o), .pre_wait_o(pre_wait_o), .act_wait_o(act_wait_o),
    .viol_o(viol_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_to(int t);
    while (int'(cycle_o) < t) @(negedge clk);
  endtask

  // pulse one command at the current negedge, return its timestamp
  task automatic issue(string c, output int t);
    t = int'(cycle_o);
    case (c)
      "act": act_i = 1;  "rd": rd_i = 1;
      "wr":  wr_i = 1;   default: pre_i = 1;
    endcase
    @(negedge clk);
    act_i = 0; rd_i = 0; wr_i = 0; pre_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1; idle(3);
    chk("R1", "col_ok in reset", col_ok_o, 1);
    rst = 0; @(negedge clk);
    chk("R1", "cycle", cycle_o, 1);
    chk("R1", "pre_ok", pre_ok_o, 1);
    chk("R1", "act_ok", act_ok_o, 1);
    chk("R1", "waits", col_wait_o + pre_wait_o + act_wait_o, 0);
    chk("R1", "viol", viol_o, 0);
    @(negedge clk);
    chk("R10", "cycle step", cycle_o, 2);
  endtask

  task automatic t_read;
    int t;
    issue("rd", t);
    chk("R2", "col_ok after rd", col_ok_o, 0);
    chk("R2", "col_wait after rd", col_wait_o, TBURST - 1);
    chk("R3", "pre_wait after rd", pre_wait_o, EXP_RTP - 1);
    chk("R9", "derived rtp", pre_wait_o + 1, 6);
    wait_to(t + TBURST - 1);
    chk("R2", "col_ok last blocked", col_ok_o, 0);
    wait_to(t + TBURST);
    chk("R2", "col_ok released", col_ok_o, 1);
    wait_to(t + EXP_RTP - 1);
    chk("R3", "pre_ok last blocked", pre_ok_o, 0);
    wait_to(t + EXP_RTP);
    chk("R3", "pre_ok released", pre_ok_o, 1);
    chk("R11", "pre_wait zero", pre_wait_o, 0);
  endtask

  task automatic t_write;
    int t;
    idle(5);
    issue("wr", t);
    chk("R4", "pre_wait after wr", pre_wait_o, TCL + TBURST + TWR - 1);
    chk("R2", "col_wait after wr", col_wait_o, TBURST - 1);
    wait_to(t + TCL + TBURST + TWR - 1);
    chk("R4", "pre_ok last blocked", pre_ok_o, 0);
    wait_to(t + TCL + TBURST + TWR);
    chk("R4", "pre_ok released", pre_ok_o, 1);
  endtask

  task automatic t_act_merge;
    int a, t;
    idle(5);
    issue("act", a);
    chk("R6", "pre_wait after act", pre_wait_o, TRAS - 1);
    chk("R6", "col_wait after act", col_wait_o, TRCD - 1);
    wait_to(a + TRCD - 1);
    chk("R6", "col_ok last blocked", col_ok_o, 0);
    wait_to(a + TRCD);
    chk("R6", "col_ok released", col_ok_o, 1);
    issue("rd", t);
    chk("R5", "rd keeps tRAS limit", pre_wait_o, a + TRAS - (t + 1));
    wait_to(t + TBURST);
    issue("wr", t);
    chk("R5", "wr extends limit", pre_wait_o, TCL + TBURST + TWR - 1);
    wait_to(t + TCL + TBURST + TWR);
    chk("R5", "pre_ok at wr limit", pre_ok_o, 1);
    issue("pre", t);
    chk("R7", "act_ok after pre", act_ok_o, 0);
    chk("R7", "act_wait after pre", act_wait_o, TRP - 1);
    wait_to(t + TRP - 1);
    chk("R7", "act_ok last blocked", act_ok_o, 0);
    wait_to(t + TRP);
    chk("R7", "act_ok released", act_ok_o, 1);
    chk("R8", "no viol on legal flow", viol_o, 0);
  endtask

  task automatic t_violation;
    int t;
    idle(5);
    issue("pre", t);
    chk("R8", "viol before early act", viol_o, 0);
    issue("act", t);
    chk("R8", "viol after early act", viol_o, 1);
    idle(30);
    chk("R8", "viol sticky", viol_o, 1);
    t_reset();
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_act_merge();
    t_violation();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule